// File: doc/BRIEF.md
# NAND Hamming Parity Code Generator

This block computes a 24-bit row/column Hamming code over one block of NAND page data while the data streams past on its way to or from the flash. The code supports single-bit correction and double-bit detection in the software or logic downstream. Each bit of the block has a position `p = 8*byte_index + bit_index`. For every bit `k` of that position there are two parity terms. The even term is the XOR of all data bits whose position has bit `k` clear, and the odd term is the XOR of all data bits whose position has bit `k` set. The three lowest terms depend on the bit within a byte (the column terms). The higher terms depend on the byte address (the line terms).

Data arrive on a valid/ready stream. The block never applies back-pressure: `data_ready` is held high, and a beat is consumed in every cycle in which `data_valid` is high. In 8-bit column mode a beat carries one byte on `data_in[7:0]`. In 16-bit column mode a beat carries two bytes, and the lower byte is the lower address. A small register port sets the enable, the column mode, the block length and the result pointer, and starts a new block with a clear. It also returns the 32-bit result word. Once the programmed byte count has been consumed, `done` rises and the result freezes until the next clear. The three code bytes are also driven continuously on `code_bytes`.

Top module: `hamming_ecc_gen`

## Requirements
- R1: After reset the result word is 0, `done` is low, the config and control registers read 0, and the size register reads 0x3FC00000, which is a 512-byte block.
- R2: The config register (address 0) holds the enable in bit 0, a 3-bit chip-select number in bits 3:1 and 16-bit column mode in bit 7. Only these bits read back; all other bits read 0.
- R3: The size register (address 2) holds an 8-bit field in bits 29:22 and a 4-bit result mask in bits 3:0. The block length is 2*(field+1) bytes. Only these bits read back.
- R4: A write to the control register (address 1) with bit 8 set clears the parity terms, the byte count and `done`, taking effect at that clock edge. Bits 3:0 of the same write are stored as the result pointer and read back at address 1. The value 0x101 clears and sets the pointer to 1; 0x100 clears and sets it to 0.
- R5: In 8-bit mode an accepted beat supplies one byte from `data_in[7:0]`, and `data_in[15:8]` is ignored. In 16-bit mode an accepted beat supplies `data_in[7:0]` at the current byte address and `data_in[15:8]` at the next one.
- R6: The result word (address 3) holds even term k in bit k and odd term k in bit 16+k, for k = 0..11, using the position definition above. Bits 15:12 and 31:28 read 0.
- R7: `done` rises in the cycle after the beat that brings the byte count to the block length. While `done` is high, further beats change neither the result nor `done` until a clear.
- R8: While the enable bit is 0, beats change neither the result, the byte count nor `done`.
- R9: `code_bytes[7:0]` equals result bits 7:0, `code_bytes[15:8]` equals result bits 23:16, and `code_bytes[23:16]` equals {result bits 27:24, result bits 11:8}.
- R10: `data_ready` is high whenever reset is released, and only cycles with `data_valid` high advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 control, 2 size, 3 result |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| data_valid | input | 1 | Stream beat present |
| data_ready | output | 1 | Stream sink ready, always high |
| data_in | input | 16 | Stream data, low byte first |
| done | output | 1 | Block complete, result frozen |
| code_bytes | output | 24 | Packed three-byte code |

## Verification
A wrong byte count shows up at the ports in one of two ways. `done` rises a beat early or late, which is visible the cycle after the offending beat. Or beats continue to alter the result after the block should have closed. A misplaced bit position or lane order corrupts a specific even/odd pair of result bits, and the bench traces such an error to a single term by streaming single set bits at the first and last positions of the block. A stale accumulator after a clear appears on the result register in the very next cycle. A leaking enable shows as a nonzero result after beats sent while disabled.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    RSEL_CFG  = 2'd0,
    RSEL_CTL  = 2'd1,
    RSEL_SIZE = 2'd2,
    RSEL_RES  = 2'd3
  } reg_sel_e;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_CS_LSB   = 1;
  localparam int CFG_CS_W     = 3;
  localparam int CFG_WIDE_BIT = 7;
  localparam int CTL_CLR_BIT  = 8;
  localparam int CTL_PTR_W    = 4;
  localparam int SIZE_LSB     = 22;
  localparam int SIZE_MASK_W  = 4;
  localparam int ODD_LSB      = 16;
  localparam int WORD_W       = 32;
  localparam int BEAT_W       = 16;
  localparam int LANE_W       = 8;

  // Pack the result word into three code bytes: low evens, low odds, high nibbles.
  function automatic logic [23:0] pack_code(input logic [WORD_W-1:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

endpackage

// File: rtl/ecc_beat_parity.sv
module ecc_beat_parity
  import ecc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int NTERM = 12
) (
  input  logic [CNT_W-1:0]  base_byte,
  input  logic [BEAT_W-1:0] data,
  input  logic              wide,
  output logic [NTERM-1:0]  even_x,
  output logic [NTERM-1:0]  odd_x
);

  localparam int POS_W = CNT_W + 3;

  logic [POS_W-1:0]  pos [BEAT_W];
  logic [BEAT_W-1:0] lane_on;

  // Bit position of every lane within the block, and whether the lane is live.
  for (genvar j = 0; j < BEAT_W; j++) begin : g_lane
    assign pos[j] = {base_byte, 3'b000} + POS_W'(j);
    if (j < LANE_W) begin : g_low
      assign lane_on[j] = 1'b1;
    end else begin : g_high
      assign lane_on[j] = wide;
    end
  end

  // Each set data bit toggles, for each position bit k, either the odd or the even term.
  always_comb begin
    even_x = '0;
    odd_x  = '0;
    for (int j = 0; j < BEAT_W; j++) begin
      for (int k = 0; k < NTERM; k++) begin
        if (lane_on[j] && data[j]) begin
          if (pos[j][k]) odd_x[k]  = ~odd_x[k];
          else           even_x[k] = ~even_x[k];
        end
      end
    end
  end

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
  import ecc_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int CNT_W  = SIZE_W + 2,
  parameter int NTERM  = SIZE_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              beat,
  input  logic              wide,
  input  logic [BEAT_W-1:0] data,
  input  logic [SIZE_W-1:0] size_field,
  output logic [NTERM-1:0]  even_q,
  output logic [NTERM-1:0]  odd_q,
  output logic              done_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] block_bytes;
  logic [CNT_W-1:0] step;
  logic [NTERM-1:0] even_x;
  logic [NTERM-1:0] odd_x;
  logic             take;

  assign block_bytes = CNT_W'({size_field, 1'b0}) + CNT_W'(2);
  assign step        = wide ? CNT_W'(2) : CNT_W'(1);
  assign cnt_nxt     = cnt_q + step;
  assign take        = beat && !done_q;

  ecc_beat_parity #(
    .CNT_W (CNT_W),
    .NTERM (NTERM)
  ) u_beat (
    .base_byte (cnt_q),
    .data      (data),
    .wide      (wide),
    .even_x    (even_x),
    .odd_x     (odd_x)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q  <= '0;
      even_q <= '0;
      odd_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_nxt;
      even_q <= even_q ^ even_x;
      odd_q  <= odd_q ^ odd_x;
      if (cnt_nxt >= block_bytes) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
  import ecc_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] result,
  output logic [WORD_W-1:0] rdata,
  output logic              cfg_en,
  output logic              cfg_wide,
  output logic [SIZE_W-1:0] size_field,
  output logic              clr_pulse
);

  logic [CFG_CS_W-1:0]    cs_q;
  logic [CTL_PTR_W-1:0]   ptr_q;
  logic [SIZE_MASK_W-1:0] mask_q;
  reg_sel_e               sel;

  assign sel       = reg_sel_e'(addr);
  assign clr_pulse = we && (sel == RSEL_CTL) && wdata[CTL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_wide   <= 1'b0;
      cs_q       <= '0;
      ptr_q      <= '0;
      mask_q     <= '0;
      size_field <= '1;
    end else if (we) begin
      unique case (sel)
        RSEL_CFG: begin
          cfg_en   <= wdata[CFG_EN_BIT];
          cfg_wide <= wdata[CFG_WIDE_BIT];
          cs_q     <= wdata[CFG_CS_LSB +: CFG_CS_W];
        end
        RSEL_CTL:  ptr_q <= wdata[CTL_PTR_W-1:0];
        RSEL_SIZE: begin
          size_field <= wdata[SIZE_LSB +: SIZE_W];
          mask_q     <= wdata[SIZE_MASK_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      RSEL_CFG: begin
        rdata[CFG_EN_BIT]              = cfg_en;
        rdata[CFG_WIDE_BIT]            = cfg_wide;
        rdata[CFG_CS_LSB +: CFG_CS_W]  = cs_q;
      end
      RSEL_CTL:  rdata[CTL_PTR_W-1:0] = ptr_q;
      RSEL_SIZE: begin
        rdata[SIZE_LSB +: SIZE_W]      = size_field;
        rdata[SIZE_MASK_W-1:0]         = mask_q;
      end
      RSEL_RES:  rdata = result;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/hamming_ecc_gen.sv
module hamming_ecc_gen
  import ecc_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        data_valid,
  output logic        data_ready,
  input  logic [15:0] data_in,
  output logic        done,
  output logic [23:0] code_bytes
);

  localparam int CNT_W = SIZE_W + 2;
  localparam int NTERM = SIZE_W + 4;

  logic              cfg_en;
  logic              cfg_wide;
  logic              clr_pulse;
  logic [SIZE_W-1:0] size_field;
  logic [NTERM-1:0]  even_q;
  logic [NTERM-1:0]  odd_q;
  logic [WORD_W-1:0] result_w;

  assign data_ready = 1'b1;

  always_comb begin
    result_w = '0;
    result_w[NTERM-1:0]        = even_q;
    result_w[ODD_LSB +: NTERM] = odd_q;
  end

  assign code_bytes = pack_code(result_w);

  ecc_regs #(
    .SIZE_W (SIZE_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .result     (result_w),
    .rdata      (reg_rdata),
    .cfg_en     (cfg_en),
    .cfg_wide   (cfg_wide),
    .size_field (size_field),
    .clr_pulse  (clr_pulse)
  );

  ecc_accum #(
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W),
    .NTERM  (NTERM)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_pulse),
    .beat       (data_valid && data_ready && cfg_en),
    .wide       (cfg_wide),
    .data       (data_in),
    .size_field (size_field),
    .even_q     (even_q),
    .odd_q      (odd_q),
    .done_q     (done)
  );

endmodule

// File: rtl/hamming_ecc_chk.sv
module hamming_ecc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        data_valid,
  input logic        done,
  input logic        cfg_en,
  input logic [31:0] result
);

  logic clr_w;
  assign clr_w = reg_we && (reg_addr == 2'd1) && reg_wdata[8];

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (result == 32'd0) && !done);

  // R7
  frozen_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_w) |=> done && $stable(result));

  // R7
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(data_valid));

  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !clr_w) |=> $stable(result) && $stable(done));

endmodule

bind hamming_ecc_gen hamming_ecc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .data_valid (data_valid),
  .done       (done),
  .cfg_en     (cfg_en),
  .result     (result_w)
);

// File: tb/sim_hamming_ecc_gen.sv
`timescale 1ns/1ps
module sim_hamming_ecc_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        data_valid = 1'b0;
  logic        data_ready;
  logic [15:0] data_in = 16'd0;
  logic        done;
  logic [23:0] code_bytes;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [512];

  always #2.5 clk = ~clk;

  hamming_ecc_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_valid(data_valid),
    .data_ready(data_ready), .data_in(data_in), .done(done), .code_bytes(code_bytes)
  );

  // {wide, size field, seed}
  localparam logic [16:0] VEC [7] = '{
    {1'b0, 8'hFF, 8'h00},
    {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'hFF, 8'h5B},
    {1'b0, 8'h03, 8'h13},
    {1'b1, 8'h00, 8'h77},
    {1'b0, 8'h3F, 8'h2D},
    {1'b1, 8'h1F, 8'hC4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send_beats(input int n, input bit wide, input bit gaps);
    for (int b = 0; b < n; b++) begin
      if (gaps && (b % 3 == 2)) begin
        @(negedge clk);
        data_valid = 1'b0;
        data_in = 16'hDEAD;
      end
      @(negedge clk);
      data_valid = 1'b1;
      data_in = wide ? {mem[2*b+1], mem[2*b]} : {8'h5A, mem[b]};
    end
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  // Parity per requirement R6, computed from bit positions.
  function automatic logic [31:0] model(input int n);
    logic [31:0] r;
    r = 32'd0;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++)
        if (mem[b][i])
          for (int k = 0; k < 12; k++) begin
            int p;
            p = b * 8 + i;
            if ((p >> k) & 1) r[16+k] = ~r[16+k];
            else              r[k]    = ~r[k];
          end
    return r;
  endfunction

  function automatic logic [23:0] pack(input logic [31:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  function automatic logic [7:0] gen(input logic [7:0] seed, input int idx);
    logic [7:0] v;
    v = 8'(idx * seed) ^ 8'(idx >> 2) ^ seed;
    return (seed == 8'hFF) ? 8'hFF : v;
  endfunction

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 code", {8'd0, code_bytes}, 32'd0);
    reg_rd(2'd0, rd); check("R1 cfg", rd, 32'd0);
    reg_rd(2'd1, rd); check("R1 ctl", rd, 32'd0);
    reg_rd(2'd2, rd); check("R1 size", rd, 32'h3FC00000);
    reg_rd(2'd3, rd); check("R1 result", rd, 32'd0);
    check("R10 ready", {31'd0, data_ready}, 32'd1);

    // Register readback masks
    reg_wr(2'd0, 32'hFFFFFFFF);
    reg_rd(2'd0, rd); check("R2 cfg mask", rd, 32'h0000008F);
    reg_wr(2'd2, 32'hFFFFFFFF);
    reg_rd(2'd2, rd); check("R3 size mask", rd, 32'h3FC0000F);
    reg_wr(2'd2, 32'h00C00005);
    reg_rd(2'd2, rd); check("R3 size value", rd, 32'h00C00005);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      int nb;
      bit wide;
      wide = VEC[v][16];
      nb = 2 * (int'(VEC[v][15:8]) + 1);
      for (int b = 0; b < nb; b++) mem[b] = gen(VEC[v][7:0], b);
      reg_wr(2'd0, {24'd0, wide, 3'b000, 3'b010, 1'b1});
      reg_wr(2'd2, {2'b00, VEC[v][15:8], 22'd0});
      reg_wr(2'd1, 32'h101);
      send_beats(wide ? nb / 2 : nb, wide, v[0]);
      exp = model(nb);
      check("R7 done at block end", {31'd0, done}, 32'd1);
      reg_rd(2'd3, rd); check("R6 R5 vector result", rd, exp);
      check("R9 code packing", {8'd0, code_bytes}, {8'd0, pack(exp)});
    end

    // Single bit at position 0, 512-byte block, 8-bit mode
    for (int b = 0; b < 512; b++) mem[b] = 8'h00;
    mem[0] = 8'h01;
    reg_wr(2'd0, 32'h1);
    reg_wr(2'd2, 32'h3FC00000);
    reg_wr(2'd1, 32'h101);
    reg_rd(2'd1, rd); check("R4 pointer set", rd, 32'd1);
    send_beats(512, 1'b0, 1'b0);
    reg_rd(2'd3, rd); check("R6 first bit", rd, 32'h00000FFF);
    check("R9 first bit code", {8'd0, code_bytes}, 32'h000F00FF);

    // Single bit at last position
    mem[0] = 8'h00;
    mem[511] = 8'h80;
    reg_wr(2'd1, 32'h101);
    send_beats(511, 1'b0, 1'b0);
    check("R7 not done one byte early", {31'd0, done}, 32'd0);
    mem[0] = 8'h80;
    for (int b = 1; b < 512; b++) mem[b] = 8'h00;
    send_beats(1, 1'b0, 1'b0);
    check("R7 done on last byte", {31'd0, done}, 32'd1);
    reg_rd(2'd3, rd); check("R6 last bit", rd, 32'h0FFF0000);
    check("R9 last bit code", {8'd0, code_bytes}, 32'h00F0FF00);

    // Beats after done are ignored
    for (int b = 0; b < 8; b++) mem[b] = 8'hFF;
    send_beats(8, 1'b0, 1'b0);
    reg_rd(2'd3, rd); check("R7 frozen after done", rd, 32'h0FFF0000);
    check("R7 done held", {31'd0, done}, 32'd1);

    // Clear without pointer
    reg_wr(2'd1, 32'h100);
    reg_rd(2'd3, rd); check("R4 cleared result", rd, 32'd0);
    check("R4 cleared done", {31'd0, done}, 32'd0);
    reg_rd(2'd1, rd); check("R4 pointer zero", rd, 32'd0);

    // Disabled: beats ignored
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd2, 32'h00000000);
    for (int b = 0; b < 8; b++) mem[b] = 8'hFF;
    send_beats(8, 1'b0, 1'b1);
    reg_rd(2'd3, rd); check("R8 result untouched", rd, 32'd0);
    check("R8 done untouched", {31'd0, done}, 32'd0);

    // 8-bit mode ignores high byte; 2-byte block needs two beats
    reg_wr(2'd0, 32'h1);
    mem[0] = 8'h00; mem[1] = 8'h00;
    send_beats(1, 1'b0, 1'b0);
    check("R8 count untouched while off", {31'd0, done}, 32'd0);
    send_beats(1, 1'b0, 1'b0);
    check("R7 done after two bytes", {31'd0, done}, 32'd1);
    reg_rd(2'd3, rd); check("R5 high byte ignored", rd, 32'd0);

    // 16-bit lane order: upper byte is the next address
    reg_wr(2'd0, 32'h81);
    reg_wr(2'd1, 32'h101);
    mem[0] = 8'h00; mem[1] = 8'h01;
    send_beats(1, 1'b1, 1'b0);
    check("R5 wide one beat done", {31'd0, done}, 32'd1);
    reg_rd(2'd3, rd); check("R5 wide lane order", rd, 32'h00080FF7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule